// File: doc/BRIEF.md
# Coherent Priority Command Queue

This block is the command store that sits between a memory controller's port arbiter and its DRAM scheduler. Each arriving read or write carries a two-bit priority, the port it came from, a thread number on that port, and its already decoded chip select, bank and row. The queue keeps its entries sorted so that the head is always the next command to issue. A new command is slotted in by priority, but it never lands ahead of an entry that it is required to follow.

Three ordering constraints limit how far forward a command may move. An entry that targets the same chip select, bank and row must stay in front of the new command. This check can be switched off by a configuration input when the system already guarantees coherency. A read must stay behind any queued read from the same source, where a source is the pair of port and thread. A write must stay behind every queued write from its port, whatever the thread. Reads and writes never constrain one another through their source. The issue side removes the head whenever the downstream scheduler is ready. Occupancy, full and empty are reported each cycle.

Top module: `coherent_cmd_queue`

## Requirements
- R1: After a synchronous active-low reset the queue is empty: `occupancy` is 0, `empty` is 1, `full` is 0, `iss_valid` is 0 and `cmd_ready` is 1.
- R2: Priority 0 is the most urgent and 3 the least. Among entries it is free to pass, a new command goes ahead of every entry with a numerically larger priority value and behind entries with an equal or smaller value.
- R3: With `addr_check_en` = 1, a new command never goes ahead of a queued entry with the same chip select, bank and row, even if the new command is more urgent.
- R4: With `addr_check_en` = 0, a matching chip select, bank and row places no constraint on where the new command goes.
- R5: A new read (`cmd_wr` = 0) never goes ahead of a queued read with the same port and thread. A read from the same port with a different thread is free to pass.
- R6: A new write (`cmd_wr` = 1) never goes ahead of any queued write from the same port, whatever the thread. A write from another port is free to pass.
- R7: Reads and writes do not order each other by source. Without an address match, a write may pass a read from the same port and thread, and a read may pass a write from that source.
- R8: Sources on different ports never match. A read with the same thread number but a different port is free to pass.
- R9: With 8 entries held, `full` is 1 and `cmd_ready` is 0. A command offered in that state is not taken, and the stored contents stay the same.
- R10: When an enqueue and a dequeue happen in the same cycle, the head leaves, the new command is placed among the remaining entries, and `occupancy` does not change.
- R11: `iss_valid` is 1 exactly when the queue holds at least one entry, and the `iss_*` fields show the head. When `iss_ready` is 1, the head is removed on the clock edge. `occupancy`, `full` and `empty` track the number of stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_check_en | input | 1 | Enables the same chip select/bank/row ordering rule |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The queue can take a command (not full) |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_pri | input | 2 | Priority, 0 most urgent |
| cmd_port | input | 2 | Originating port |
| cmd_thread | input | 2 | Thread on that port |
| cmd_cs | input | 1 | Decoded chip select |
| cmd_bank | input | 2 | Decoded bank |
| cmd_row | input | 4 | Decoded row |
| iss_valid | output | 1 | The head entry is valid |
| iss_ready | input | 1 | The scheduler takes the head this cycle |
| iss_wr | output | 1 | Head type |
| iss_pri | output | 2 | Head priority |
| iss_port | output | 2 | Head port |
| iss_thread | output | 2 | Head thread |
| iss_cs | output | 1 | Head chip select |
| iss_bank | output | 2 | Head bank |
| iss_row | output | 4 | Head row |
| occupancy | output | 4 | Number of stored entries |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entries stored |

## Verification
The hardest cases to reach are the ones where several rules act on a crowded queue at once. One example is a barrier entry sitting deep in the queue, with more urgent entries in front of it and less urgent ones behind it, while the head is leaving in the same cycle. Directed sequences set up each rule in isolation and then drain the queue, checking the exact issue order. After that, a long pseudo-random sweep runs with each setting of the address check. It narrows the address and source fields to a few values so that collisions of every kind happen constantly, and its valid and ready rates keep the queue close to full. The outputs are compared against an arithmetic model of the requirements in every cycle.

// File: rtl/ocq_pkg.sv
// Shared widths and the stored command record for the coherent command queue.
package ocq_pkg;
    parameter int PRI_W  = 2;
    parameter int PORT_W = 2;
    parameter int THR_W  = 2;
    parameter int CS_W   = 1;
    parameter int BANK_W = 2;
    parameter int ROW_W  = 4;

    typedef struct packed {
        logic              wr;
        logic [PRI_W-1:0]  pri;
        logic [PORT_W-1:0] port;
        logic [THR_W-1:0]  thr;
        logic [CS_W-1:0]   cs;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
    } ocq_cmd_t;
endpackage

// File: rtl/ocq_order_rule.sv
// Compares one stored entry against the incoming command.
// must_follow: the newcomer may not be placed ahead of this entry.
// yields: the entry is strictly less urgent than the newcomer.
// Assumes the caller masks both outputs with the entry's occupancy.
module ocq_order_rule
    import ocq_pkg::*;
(
    input  ocq_cmd_t entry,
    input  ocq_cmd_t incoming,
    input  logic     addr_check_en,
    output logic     must_follow,
    output logic     yields
);
    logic same_addr;
    logic same_port;
    logic same_src;

    // Decide the ordering relation between the entry and the newcomer.
    always_comb begin
        same_addr   = (entry.cs == incoming.cs) && (entry.bank == incoming.bank)
                      && (entry.row == incoming.row);
        same_port   = (entry.port == incoming.port);
        same_src    = same_port && (entry.thr == incoming.thr);
        must_follow = (addr_check_en && same_addr)
                      || (!entry.wr && !incoming.wr && same_src)
                      || (entry.wr && incoming.wr && same_port);
        yields      = (entry.pri > incoming.pri);
    end
endmodule

// File: rtl/ocq_slot_picker.sv
// Picks the insertion index for a new command. The last occupied entry that
// must be followed sets a floor. At or behind the floor, the first less
// urgent entry is displaced. With none, the command goes to the tail.
// Assumes live[] is a thermometer code of the queue occupancy.
module ocq_slot_picker #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] live,
    input  logic [DEPTH-1:0] follow,
    input  logic [DEPTH-1:0] yields,
    input  logic [CNT_W-1:0] fill,
    output logic [CNT_W-1:0] pos
);
    logic [CNT_W-1:0] floor_idx;
    logic             found;

    // Scan for the barrier and then for the first displaced entry behind it.
    always_comb begin
        floor_idx = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (live[j] && follow[j]) floor_idx = CNT_W'(j + 1);
        end
        pos   = fill;
        found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && live[i] && (CNT_W'(i) >= floor_idx) && yields[i]) begin
                pos   = CNT_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coherent_cmd_queue.sv
// Sorted memory command queue with coherency and per-source ordering.
// Entry 0 is the head and is issued next. A new command is written into its
// slot, and the entries behind it shift down one position in the same cycle.
// When a pop and a push coincide, placement is computed on the queue as it
// stands after the pop. Assumes the scheduler samples the iss_* fields only
// while iss_valid is high.
module coherent_cmd_queue
    import ocq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_check_en,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_wr,
    input  logic [PRI_W-1:0]  cmd_pri,
    input  logic [PORT_W-1:0] cmd_port,
    input  logic [THR_W-1:0]  cmd_thread,
    input  logic [CS_W-1:0]   cmd_cs,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ROW_W-1:0]  cmd_row,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic              iss_wr,
    output logic [PRI_W-1:0]  iss_pri,
    output logic [PORT_W-1:0] iss_port,
    output logic [THR_W-1:0]  iss_thread,
    output logic [CS_W-1:0]   iss_cs,
    output logic [BANK_W-1:0] iss_bank,
    output logic [ROW_W-1:0]  iss_row,
    output logic [$clog2(DEPTH+1)-1:0] occupancy,
    output logic              full,
    output logic              empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    ocq_cmd_t         slots [DEPTH];
    ocq_cmd_t         view  [DEPTH];
    ocq_cmd_t         nxt   [DEPTH];
    ocq_cmd_t         incoming;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] fill;
    logic [CNT_W-1:0] pos;
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] follow;
    logic [DEPTH-1:0] yields;
    logic             pop;
    logic             accept;

    // Pack the incoming command and derive the handshake events.
    always_comb begin
        incoming.wr   = cmd_wr;
        incoming.pri  = cmd_pri;
        incoming.port = cmd_port;
        incoming.thr  = cmd_thread;
        incoming.cs   = cmd_cs;
        incoming.bank = cmd_bank;
        incoming.row  = cmd_row;
        cmd_ready     = (count != CNT_W'(DEPTH));
        accept        = cmd_valid && cmd_ready;
        pop           = iss_ready && (count != '0);
        fill          = count - CNT_W'(pop);
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            // Contents seen by the insertion logic, with the head already removed on a pop.
            if (g < DEPTH - 1) begin : g_mid
                assign view[g] = pop ? slots[g+1] : slots[g];
            end else begin : g_last
                assign view[g] = pop ? ocq_cmd_t'('0) : slots[g];
            end

            assign live[g] = (CNT_W'(g) < fill);

            ocq_order_rule u_rule (
                .entry         (view[g]),
                .incoming      (incoming),
                .addr_check_en (addr_check_en),
                .must_follow   (follow[g]),
                .yields        (yields[g])
            );

            // Next contents: keep, take the newcomer, or take the neighbour above.
            if (g == 0) begin : g_head
                assign nxt[g] = (accept && pos == '0) ? incoming : view[g];
            end else begin : g_body
                assign nxt[g] = !accept              ? view[g]
                              : (CNT_W'(g) < pos)    ? view[g]
                              : (CNT_W'(g) == pos)   ? incoming
                              :                        view[g-1];
            end
        end
    endgenerate

    ocq_slot_picker #(.DEPTH(DEPTH)) u_pick (
        .live   (live),
        .follow (follow),
        .yields (yields),
        .fill   (fill),
        .pos    (pos)
    );

    // Register the shifted contents and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else begin
            count <= fill + CNT_W'(accept);
            for (int i = 0; i < DEPTH; i++) slots[i] <= nxt[i];
        end
    end

    // Present the head and the status flags.
    always_comb begin
        iss_valid  = (count != '0);
        iss_wr     = slots[0].wr;
        iss_pri    = slots[0].pri;
        iss_port   = slots[0].port;
        iss_thread = slots[0].thr;
        iss_cs     = slots[0].cs;
        iss_bank   = slots[0].bank;
        iss_row    = slots[0].row;
        occupancy  = count;
        full       = (count == CNT_W'(DEPTH));
        empty      = (count == '0);
    end

    assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !cmd_ready);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH));

    assert_empty_no_issue_R11: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !iss_valid);

    assert_swap_keeps_depth_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && iss_ready && iss_valid) |=> $stable(occupancy));

    assert_idle_head_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready && !cmd_valid) |=>
            ($stable(iss_row) && $stable(iss_pri) && $stable(iss_port) && $stable(occupancy)));

    assert_insert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (pos <= fill));
endmodule

// File: tb/sim_coherent_cmd_queue.sv
module sim_coherent_cmd_queue;
    import ocq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_check_en = 1'b1;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic cmd_wr = 1'b0;
    logic [PRI_W-1:0]  cmd_pri = '0;
    logic [PORT_W-1:0] cmd_port = '0;
    logic [THR_W-1:0]  cmd_thread = '0;
    logic [CS_W-1:0]   cmd_cs = '0;
    logic [BANK_W-1:0] cmd_bank = '0;
    logic [ROW_W-1:0]  cmd_row = '0;
    logic iss_valid;
    logic iss_ready = 1'b0;
    logic iss_wr;
    logic [PRI_W-1:0]  iss_pri;
    logic [PORT_W-1:0] iss_port;
    logic [THR_W-1:0]  iss_thread;
    logic [CS_W-1:0]   iss_cs;
    logic [BANK_W-1:0] iss_bank;
    logic [ROW_W-1:0]  iss_row;
    logic [3:0] occupancy;
    logic full;
    logic empty;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    ocq_cmd_t mq [N];
    int mcnt = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    coherent_cmd_queue #(.DEPTH(N)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_check_en(addr_check_en),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_wr(cmd_wr),
        .cmd_pri(cmd_pri), .cmd_port(cmd_port), .cmd_thread(cmd_thread),
        .cmd_cs(cmd_cs), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_wr(iss_wr),
        .iss_pri(iss_pri), .iss_port(iss_port), .iss_thread(iss_thread),
        .iss_cs(iss_cs), .iss_bank(iss_bank), .iss_row(iss_row),
        .occupancy(occupancy), .full(full), .empty(empty)
    );

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic ocq_cmd_t mk(bit wr, int pri, int port, int thr, int cs, int bank, int row);
        ocq_cmd_t c;
        c.wr = wr; c.pri = PRI_W'(pri); c.port = PORT_W'(port); c.thr = THR_W'(thr);
        c.cs = CS_W'(cs); c.bank = BANK_W'(bank); c.row = ROW_W'(row);
        return c;
    endfunction

    function automatic bit blocks(ocq_cmd_t e, ocq_cmd_t c, bit en);
        bit a = en && e.cs == c.cs && e.bank == c.bank && e.row == c.row;
        bit r = !e.wr && !c.wr && e.port == c.port && e.thr == c.thr;
        bit w = e.wr && c.wr && e.port == c.port;
        return a || r || w;
    endfunction

    // Model of one clock edge, written from the requirements.
    task automatic model_step(bit acc, bit pp, ocq_cmd_t c, bit en);
        ocq_cmd_t v [N];
        int vc, fl, p;
        for (int i = 0; i < N; i++) v[i] = pp ? ((i < N-1) ? mq[i+1] : '0) : mq[i];
        vc = mcnt - (pp ? 1 : 0);
        if (acc) begin
            fl = 0;
            for (int j = 0; j < vc; j++) if (blocks(v[j], c, en)) fl = j + 1;
            p = vc;
            for (int i = vc - 1; i >= fl; i--) if (v[i].pri > c.pri) p = i;
            for (int i = vc; i > p; i--) v[i] = v[i-1];
            v[p] = c;
            vc++;
        end
        mq = v;
        mcnt = vc;
    endtask

    // Drive one cycle from a falling edge, then compare at the next falling edge.
    task automatic tick(bit v, ocq_cmd_t c, bit rdy);
        bit acc, pp;
        ocq_cmd_t h;
        cmd_valid = v; iss_ready = rdy;
        cmd_wr = c.wr; cmd_pri = c.pri; cmd_port = c.port; cmd_thread = c.thr;
        cmd_cs = c.cs; cmd_bank = c.bank; cmd_row = c.row;
        acc = v && (mcnt < N);
        pp = rdy && (mcnt > 0);
        chk("R9 cmd_ready", int'(cmd_ready), (mcnt < N) ? 1 : 0);
        model_step(acc, pp, c, addr_check_en);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; iss_ready = 1'b0;
        chk("R11 occupancy", int'(occupancy), mcnt);
        chk("R11 empty", int'(empty), (mcnt == 0) ? 1 : 0);
        chk("R9 full", int'(full), (mcnt == N) ? 1 : 0);
        chk("R11 iss_valid", int'(iss_valid), (mcnt > 0) ? 1 : 0);
        if (mcnt > 0) begin
            h = mk(iss_wr, iss_pri, iss_port, iss_thread, iss_cs, iss_bank, iss_row);
            chk("R2 head entry", int'(h), int'(mq[0]));
        end
    endtask

    task automatic push(ocq_cmd_t c);
        tick(1'b1, c, 1'b0);
    endtask

    // Check the head against an explicitly stated expectation, then pop it.
    task automatic pop_expect(string tag, int row, int pri);
        chk(tag, int'(iss_valid), 1);
        chk(tag, int'(iss_row), row);
        chk(tag, int'(iss_pri), pri);
        tick(1'b0, '0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 occupancy", int'(occupancy), 0);
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 iss_valid", int'(iss_valid), 0);
        chk("R1 cmd_ready", int'(cmd_ready), 1);

        // R2: priority placement among unrelated reads
        addr_check_en = 1'b1;
        push(mk(0, 2, 0, 0, 0, 0, 1));
        push(mk(0, 1, 1, 0, 0, 0, 2));
        push(mk(0, 0, 2, 0, 0, 0, 3));
        push(mk(0, 1, 3, 0, 0, 0, 4));
        pop_expect("R2 order", 3, 0);
        pop_expect("R2 order", 2, 1);
        pop_expect("R2 order", 4, 1);
        pop_expect("R2 order", 1, 2);

        // R3: same chip select/bank/row held behind even when more urgent
        push(mk(0, 3, 0, 0, 0, 1, 5));
        push(mk(0, 0, 1, 0, 0, 1, 5));
        pop_expect("R3 collision", 5, 3);
        pop_expect("R3 collision", 5, 0);

        // R4: rule disabled, urgent command passes
        addr_check_en = 1'b0;
        push(mk(0, 3, 0, 0, 0, 1, 5));
        push(mk(0, 0, 1, 0, 0, 1, 5));
        pop_expect("R4 no collision", 5, 0);
        pop_expect("R4 no collision", 5, 3);

        // R5: reads from one source stay in order; other thread passes
        push(mk(0, 3, 1, 2, 0, 0, 6));
        push(mk(0, 0, 1, 2, 0, 0, 7));
        push(mk(0, 0, 1, 3, 0, 0, 8));
        pop_expect("R5 read source", 8, 0);
        pop_expect("R5 read source", 6, 3);
        pop_expect("R5 read source", 7, 0);

        // R6: writes per port stay in order; other port passes
        push(mk(1, 3, 2, 0, 0, 0, 9));
        push(mk(1, 0, 2, 1, 0, 0, 10));
        push(mk(1, 0, 3, 1, 0, 0, 11));
        pop_expect("R6 write port", 11, 0);
        pop_expect("R6 write port", 9, 3);
        pop_expect("R6 write port", 10, 0);

        // R7: reads and writes of one source do not order each other
        push(mk(0, 3, 0, 1, 0, 0, 12));
        push(mk(1, 0, 0, 1, 0, 0, 13));
        push(mk(0, 0, 0, 1, 0, 0, 14));
        pop_expect("R7 cross type", 13, 0);
        pop_expect("R7 cross type", 12, 3);
        pop_expect("R7 cross type", 14, 0);

        // R8: same thread number on another port is a different source
        push(mk(0, 3, 0, 0, 0, 0, 1));
        push(mk(0, 0, 1, 0, 0, 0, 2));
        pop_expect("R8 port split", 2, 0);
        pop_expect("R8 port split", 1, 3);

        // R9: fill, refuse, drain in order
        for (int i = 0; i < N; i++) push(mk(0, 1, i % 4, i / 4, 0, 0, i));
        chk("R9 full flag", int'(full), 1);
        chk("R9 ready low", int'(cmd_ready), 0);
        push(mk(0, 0, 0, 3, 0, 3, 15));
        chk("R9 refused depth", int'(occupancy), N);
        for (int i = 0; i < N; i++) pop_expect("R9 drain", i, 1);
        chk("R9 drained", int'(empty), 1);

        // R10: push and pop in one cycle
        push(mk(0, 2, 0, 0, 0, 0, 1));
        push(mk(0, 2, 1, 0, 0, 0, 2));
        tick(1'b1, mk(0, 0, 0, 0, 0, 0, 3), 1'b1);
        chk("R10 depth kept", int'(occupancy), 2);
        pop_expect("R10 swap", 3, 0);
        pop_expect("R10 swap", 2, 2);

        // R11: pseudo-random sweep with dense collisions, both settings
        for (int ph = 0; ph < 2; ph++) begin
            addr_check_en = (ph == 0);
            for (int k = 0; k < 1500; k++) begin
                seed = seed ^ (seed << 13);
                seed = seed ^ (seed >> 17);
                seed = seed ^ (seed << 5);
                tick(seed[0] | seed[1],
                     mk(seed[2], int'(seed[4:3]), int'(seed[6:5]), int'(seed[7]),
                        0, int'(seed[8]), int'(seed[10:9])),
                     seed[11] & seed[12]);
            end
            while (mcnt > 0) tick(1'b0, '0, 1'b1);
            chk("R11 sweep drained", int'(empty), 1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule